// File: doc/BRIEF.md
# Gapped Serial Timeslot Gate

This block controls one framed serial TDM backplane port. It tracks where the current bit sits in the frame, and from that position it decides whether the current bit belongs to an active timeslot. For an active bit it raises a sample enable for the receive side and drives the transmit data and control bits onto the port. For an inactive bit it releases both outputs to high impedance. The enables are separate, so the pad ring can build the tristate drivers.

There are two rates. At the base rate of 2.048 Mb/s a frame has 32 eight-bit timeslots, and every timeslot is active. At the gapped rate of 8.192 Mb/s a frame has 128 timeslots, and only one timeslot in four is active. A two-bit group select picks which of the four interleaved groups the port owns. The frame pulse marks bit 0 of timeslot 0. The rate and group settings are taken only on a frame pulse, so a frame is never split between two configurations.

Top module: `tdm_slot_gate`

## Requirements
- R1: After reset, and until the first frame pulse, the gate is closed: sample_en_o, data_oe_o and ctrl_oe_o are 0, and data_o and ctrl_o are 0.
- R2: The bit sampled together with a high frame_pulse_i is bit 0 of timeslot 0. Each timeslot is 8 consecutive bits, and the timeslot index is the bit position divided by 8.
- R3: With high_rate_i = 0 a frame is 256 bits, and every bit is active (256 active bits per frame) whatever the value of slot_sel_i.
- R4: With high_rate_i = 1 a frame is 1024 bits (128 timeslots). A timeslot is active exactly when its index modulo 4 equals slot_sel_i (0 gives 0,4,…,124, and 3 gives 3,7,…,127), which makes 256 active bits per frame.
- R5: During an active bit, sample_en_o, data_oe_o and ctrl_oe_o are 1, data_o equals tx_data_i and ctrl_o equals tx_ctrl_i, all in the same cycle.
- R6: During an inactive bit, sample_en_o, data_oe_o and ctrl_oe_o are 0, and data_o and ctrl_o are held at 0.
- R7: high_rate_i and slot_sel_i are captured only in a cycle where frame_pulse_i is high, and they apply from that bit on. Changes at any other time have no effect until the next frame pulse.
- R8: Without a new frame pulse, the position wraps from the last bit of the frame (255 at the base rate, 1023 at the gapped rate) to bit 0 of timeslot 0, and gating continues.
- R9: A frame pulse in the middle of a frame restarts the position at bit 0 of timeslot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock, one bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_pulse_i | input | 1 | High during bit 0 of timeslot 0 |
| high_rate_i | input | 1 | 0: base rate, 32 timeslots; 1: gapped rate, 128 timeslots |
| slot_sel_i | input | 2 | Active timeslot group in gapped mode |
| tx_data_i | input | 1 | Transmit data bit for the current position |
| tx_ctrl_i | input | 1 | Transmit control bit for the current position |
| sample_en_o | output | 1 | Receive side may sample data and control this bit |
| data_o | output | 1 | Data output value |
| data_oe_o | output | 1 | Data output enable (0 = high impedance) |
| ctrl_o | output | 1 | Control output value |
| ctrl_oe_o | output | 1 | Control output enable (0 = high impedance) |

## Verification
Every output follows its inputs with no delay. The gate decision for a bit depends on that bit's own frame pulse, rate and group inputs, and on the position and configuration registered at the previous rising edge. The bench therefore changes inputs on the falling edge and compares all five outputs 1 ns later, in the same cycle. It then advances its own arithmetic model of the position and the configuration, to match the register update at the next rising edge. Per-frame counts of active bits are checked after each full frame of such per-bit comparisons.

// File: rtl/tdm_gate_pkg.sv
`timescale 1ns/1ps
package tdm_gate_pkg;
   typedef enum logic {
      RATE_BASE   = 1'b0,
      RATE_GAPPED = 1'b1
   } rate_e;

   function automatic int unsigned sel_width(input int unsigned mult);
      return (mult > 1) ? $clog2(mult) : 1;
   endfunction
endpackage

// File: rtl/tdm_cfg_latch.sv
`timescale 1ns/1ps
module tdm_cfg_latch
   import tdm_gate_pkg::*;
#(
   parameter int unsigned SEL_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             frame_pulse_i,
   input  logic             high_rate_i,
   input  logic [SEL_W-1:0] sel_i,
   output rate_e            rate_o,
   output logic [SEL_W-1:0] sel_o,
   output logic             synced_o
);
   rate_e            rate_q;
   logic [SEL_W-1:0] sel_q;
   logic             synced_q;

   always_comb begin
      if (frame_pulse_i) begin
         rate_o   = rate_e'(high_rate_i);
         sel_o    = sel_i;
         synced_o = 1'b1;
      end else begin
         rate_o   = rate_q;
         sel_o    = sel_q;
         synced_o = synced_q;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rate_q   <= RATE_BASE;
         sel_q    <= '0;
         synced_q <= 1'b0;
      end else begin
         rate_q   <= rate_o;
         sel_q    <= sel_o;
         synced_q <= synced_o;
      end
   end

   // R7
   cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frame_pulse_i |=> ($stable(rate_q) && $stable(sel_q)));
endmodule

// File: rtl/tdm_frame_counter.sv
`timescale 1ns/1ps
module tdm_frame_counter
   import tdm_gate_pkg::*;
#(
   parameter int unsigned SLOT_BITS  = 8,
   parameter int unsigned BASE_SLOTS = 32,
   parameter int unsigned RATE_MULT  = 4,
   parameter int unsigned SEL_W      = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             frame_pulse_i,
   input  rate_e            rate_i,
   output logic [SEL_W-1:0] group_o
);
   localparam int unsigned BASE_LEN = SLOT_BITS * BASE_SLOTS;
   localparam int unsigned GAP_LEN  = BASE_LEN * RATE_MULT;
   localparam int unsigned POS_W    = $clog2(GAP_LEN);
   localparam int unsigned BIT_W    = $clog2(SLOT_BITS);

   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] cur_pos;
   logic [POS_W-1:0] last_pos;

   assign cur_pos  = frame_pulse_i ? '0 : pos_q;
   assign last_pos = (rate_i == RATE_GAPPED) ? POS_W'(GAP_LEN - 1) : POS_W'(BASE_LEN - 1);
   assign group_o  = cur_pos[BIT_W +: SEL_W];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pos_q <= '0;
      end else if (cur_pos == last_pos) begin
         pos_q <= '0;
      end else begin
         pos_q <= cur_pos + POS_W'(1);
      end
   end

   // R9
   frame_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_pulse_i |=> (pos_q == POS_W'(1)));

   // R8
   base_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!frame_pulse_i && rate_i == RATE_BASE && pos_q == POS_W'(BASE_LEN - 1))
      |=> (pos_q == '0));
endmodule

// File: rtl/tdm_slot_decode.sv
`timescale 1ns/1ps
module tdm_slot_decode
   import tdm_gate_pkg::*;
#(
   parameter int unsigned RATE_MULT = 4,
   parameter int unsigned SEL_W     = 2
) (
   input  rate_e            rate_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             synced_i,
   input  logic [SEL_W-1:0] group_i,
   output logic             open_o
);
   generate
      if (RATE_MULT == 1) begin : g_single
         logic unused_in;
         assign unused_in = ^{rate_i, sel_i, group_i};
         assign open_o    = synced_i;
      end else begin : g_interleaved
         assign open_o = synced_i && ((rate_i == RATE_BASE) || (group_i == sel_i));
      end
   endgenerate
endmodule

// File: rtl/tdm_slot_gate.sv
`timescale 1ns/1ps
module tdm_slot_gate
   import tdm_gate_pkg::*;
#(
   parameter int unsigned SLOT_BITS  = 8,
   parameter int unsigned BASE_SLOTS = 32,
   parameter int unsigned RATE_MULT  = 4,
   parameter int unsigned SEL_W      = sel_width(RATE_MULT)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             frame_pulse_i,
   input  logic             high_rate_i,
   input  logic [SEL_W-1:0] slot_sel_i,
   input  logic             tx_data_i,
   input  logic             tx_ctrl_i,
   output logic             sample_en_o,
   output logic             data_o,
   output logic             data_oe_o,
   output logic             ctrl_o,
   output logic             ctrl_oe_o
);
   generate
      if (SLOT_BITS < 2 || (SLOT_BITS & (SLOT_BITS - 1)) != 0) begin : g_bad_slot
         $error("SLOT_BITS must be a power of two of at least 2");
      end
      if (RATE_MULT < 1 || (RATE_MULT & (RATE_MULT - 1)) != 0) begin : g_bad_mult
         $error("RATE_MULT must be a power of two");
      end
      if (BASE_SLOTS < RATE_MULT || (BASE_SLOTS & (BASE_SLOTS - 1)) != 0) begin : g_bad_slots
         $error("BASE_SLOTS must be a power of two not below RATE_MULT");
      end
      if (SEL_W != sel_width(RATE_MULT)) begin : g_bad_sel
         $error("SEL_W must match RATE_MULT");
      end
   endgenerate

   rate_e            rate_eff;
   logic [SEL_W-1:0] sel_eff;
   logic             synced;
   logic [SEL_W-1:0] group;
   logic             gate_open;

   tdm_cfg_latch #(.SEL_W(SEL_W)) cfg_i (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .frame_pulse_i (frame_pulse_i),
      .high_rate_i   (high_rate_i),
      .sel_i         (slot_sel_i),
      .rate_o        (rate_eff),
      .sel_o         (sel_eff),
      .synced_o      (synced)
   );

   tdm_frame_counter #(
      .SLOT_BITS  (SLOT_BITS),
      .BASE_SLOTS (BASE_SLOTS),
      .RATE_MULT  (RATE_MULT),
      .SEL_W      (SEL_W)
   ) cnt_i (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .frame_pulse_i (frame_pulse_i),
      .rate_i        (rate_eff),
      .group_o       (group)
   );

   tdm_slot_decode #(.RATE_MULT(RATE_MULT), .SEL_W(SEL_W)) dec_i (
      .rate_i   (rate_eff),
      .sel_i    (sel_eff),
      .synced_i (synced),
      .group_i  (group),
      .open_o   (gate_open)
   );

   assign sample_en_o = gate_open;
   assign data_oe_o   = gate_open;
   assign ctrl_oe_o   = gate_open;
   assign data_o      = gate_open & tx_data_i;
   assign ctrl_o      = gate_open & tx_ctrl_i;

   // R6
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sample_en_o |-> (!data_o && !ctrl_o && !data_oe_o && !ctrl_oe_o));

   // R5
   pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_en_o |-> (data_o == tx_data_i && ctrl_o == tx_ctrl_i));

   // R3
   base_all_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (synced && rate_eff == RATE_BASE) |-> sample_en_o);

   // R1
   presync_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !synced |-> (!data_oe_o && !ctrl_oe_o));
endmodule

// File: tb/tdm_slot_gate_tb.sv
`timescale 1ns/1ps
module tdm_slot_gate_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_pulse = 1'b0;
   logic       high_rate = 1'b0;
   logic [1:0] slot_sel = 2'd0;
   logic       tx_data = 1'b0;
   logic       tx_ctrl = 1'b0;
   logic       sample_en, data_o, data_oe, ctrl_o, ctrl_oe;

   int checks = 0;
   int failures = 0;
   int act_cnt = 0;
   int cyc = 0;

   bit         m_sync = 0;
   bit         m_hr = 0;
   bit [1:0]   m_sel = 0;
   int         m_pos = 0;

   always #2 clk = ~clk;

   tdm_slot_gate dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .frame_pulse_i (frame_pulse),
      .high_rate_i   (high_rate),
      .slot_sel_i    (slot_sel),
      .tx_data_i     (tx_data),
      .tx_ctrl_i     (tx_ctrl),
      .sample_en_o   (sample_en),
      .data_o        (data_o),
      .data_oe_o     (data_oe),
      .ctrl_o        (ctrl_o),
      .ctrl_oe_o     (ctrl_oe)
   );

   task automatic check_vec(input string tag, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s cyc=%0d act(en,d,doe,c,coe)=%b exp=%b", tag, cyc, act, exp);
      end
   endtask

   task automatic check_int(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   // one bit period: drive on falling edge, compare 1 ns later, advance model
   task automatic step(input bit fp, input bit hr, input bit [1:0] sel, input string tag);
      bit       e_sync, e_hr, act;
      bit [1:0] e_sel;
      int       cur, len;
      @(negedge clk);
      cyc++;
      frame_pulse = fp;
      high_rate   = hr;
      slot_sel    = sel;
      tx_data     = cyc[0] ^ cyc[3];
      tx_ctrl     = cyc[1] ^ cyc[5];
      #1;
      if (fp) begin
         e_sync = 1; e_hr = hr; e_sel = sel; cur = 0;
      end else begin
         e_sync = m_sync; e_hr = m_hr; e_sel = m_sel; cur = m_pos;
      end
      len = e_hr ? 1024 : 256;
      act = e_sync && (!e_hr || (((cur / 8) % 4) == e_sel));
      check_vec(tag, {sample_en, data_o, data_oe, ctrl_o, ctrl_oe},
                {act, act & tx_data, act, act & tx_ctrl, act});
      if (act) act_cnt++;
      m_sync = e_sync; m_hr = e_hr; m_sel = e_sel;
      m_pos  = (cur + 1) % len;
   endtask

   initial begin : watchdog
      #(4 * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : stim
      tx_data = 1'b1;
      tx_ctrl = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      // R1: reset state with live transmit inputs
      check_vec("R1 reset", {sample_en, data_o, data_oe, ctrl_o, ctrl_oe}, 5'b0);
      rst_n = 1'b1;
      // R1: no frame pulse yet, gate stays closed
      act_cnt = 0;
      for (int i = 0; i < 20; i++) step(0, 0, 2'd1, "R1 presync");
      check_int("R1 presync count", act_cnt, 0);

      // R3: base rate, select ignored, 256 active bits
      act_cnt = 0;
      step(1, 0, 2'd3, "R3 base");
      for (int i = 1; i < 256; i++) step(0, 0, 2'd3, "R3 base");
      check_int("R3 base count", act_cnt, 256);

      // R8: base rate free-running wrap, no pulse
      act_cnt = 0;
      for (int i = 0; i < 256; i++) step(0, 0, 2'd2, "R8 base wrap");
      check_int("R8 base wrap count", act_cnt, 256);

      // R2: pulse marks bit 0 of slot 0; group 1 closed for bits 0..7, open 8..15
      act_cnt = 0;
      step(1, 1, 2'd1, "R2 align");
      for (int i = 1; i < 8; i++) step(0, 1, 2'd1, "R2 align");
      check_int("R2 slot0 closed", act_cnt, 0);
      for (int i = 8; i < 16; i++) step(0, 1, 2'd1, "R2 align");
      check_int("R2 slot1 open", act_cnt, 8);

      // R4 / R5 / R6: each group select over a full gapped frame
      for (int s = 0; s < 4; s++) begin
         act_cnt = 0;
         step(1, 1, 2'(s), "R4 gapped");
         for (int i = 1; i < 1024; i++) begin
            // R7: mid-frame change of rate and select must not act
            if (s == 2 && i >= 500) step(0, 0, 2'd0, "R7 late change");
            else                    step(0, 1, 2'(s), "R4 gapped");
         end
         check_int((s == 2) ? "R7 held frame count" : "R4 gapped count", act_cnt, 256);
      end

      // R8: gapped free-running wrap
      act_cnt = 0;
      for (int i = 0; i < 1024; i++) step(0, 0, 2'd0, "R8 gapped wrap");
      check_int("R8 gapped wrap count", act_cnt, 256);

      // R9: mid-frame pulse restarts position
      step(1, 1, 2'd0, "R9 pre");
      for (int i = 1; i < 300; i++) step(0, 1, 2'd0, "R9 pre");
      act_cnt = 0;
      step(1, 1, 2'd2, "R9 restart");
      for (int i = 1; i < 1024; i++) step(0, 1, 2'd2, "R9 restart");
      check_int("R9 restart count", act_cnt, 256);

      // R7: pulse brings in base rate again
      act_cnt = 0;
      step(1, 0, 2'd1, "R7 switch");
      for (int i = 1; i < 256; i++) step(0, 1, 2'd1, "R7 switch");
      check_int("R7 switch count", act_cnt, 256);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule